// File: doc/BRIEF.md
# Memory Clock Loop Parameter Registers with Sequenced Commit

This block keeps the three loop parameters of a memory clock synthesizer behind a byte-wide I/O port pair. One port address holds an index; the other port address is a data window onto the register that the index selects. Each parameter has a staged copy that software writes and reads. It also has an active copy that drives the synthesizer through parallel outputs.

The active copy changes only when software writes all three staged registers in ascending index order: first the M-divisor, then the N-divisor, then the third parameter. When that happens, all three values move into the active copy on one clock edge, and a single-cycle update strobe tells the synthesizer that a new parameter set is in place. While new values are being written, the synthesizer therefore never sees a mix of old and new values. One copy of the register set serves both display pipelines.

Top module: `mclk_param_regs`

## Requirements
- R1: A write to address IDX_PORT (default 3D6h) loads `wdata_i` into the index register. A read of IDX_PORT returns the index register.
- R2: A write to address DAT_PORT (default 3D7h) while the index is CCh, CDh or CEh loads the staged register at positions 0, 1 or 2. A read of DAT_PORT at those indices returns that staged value.
- R3: `active_o` changes only on the clock edge that completes a valid sequence.
- R4: After writes to CCh, then CDh, then CEh, all three staged values, including the byte written to CEh, reach `active_o` on the edge of the CEh write. `update_o` is high for exactly the following cycle.
- R5: A write to CCh always starts a new sequence, whatever progress came before it.
- R6: A write to CDh or CEh that is not the next expected step clears the progress. The staged value is still written, and `active_o` is not changed.
- R7: Index-port writes, writes to out-of-window indices, and all reads that come between the steps of a sequence leave the sequence progress unchanged.
- R8: At an index outside CCh..CEh, a data-port read returns 00h and a data-port write changes nothing.
- R9: While `rst_ni` is low, the staged and active registers hold RESET_VALS, the index is 00h, the sequence is idle, and `update_o` is 0.
- R10: `active_o` bits [7:0] carry the CCh value (M-divisor), bits [15:8] carry the CDh value (N-divisor), and bits [23:16] carry the CEh value.
- R11: `rdata_o` is 00h whenever `rd_i` is low or `addr_i` matches neither port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | I/O address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| active_o | output | NUM*DATA_W | Active loop parameters, position 0 in the low byte |
| update_o | output | 1 | One-cycle strobe after a commit |

## Verification
The bench builds the block with the default port addresses, base index CCh and three 8-bit parameters. It overrides RESET_VALS with A5h/5Ah/3Ch, so that a reset load can be told apart from a committed load and from zero. With these values the index window has edges on both sides (CBh and CFh), and every order violation can be produced: a repeated step, a skipped step and a restart in mid-sequence. Accesses placed between steps test that the progress survives them. An asynchronous reset in mid-sequence is also applied.

// File: rtl/mclk_cfg_pkg.sv
package mclk_cfg_pkg;
  typedef struct packed {
    logic idx_wr;
    logic idx_rd;
    logic dat_wr;
    logic dat_rd;
  } bus_dec_t;
endpackage

// File: rtl/mclk_bus_decode.sv
module mclk_bus_decode
  import mclk_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM    = 3,
  parameter int SEL_W  = 2,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h03D6,
  parameter logic [ADDR_W-1:0] DAT_PORT = 16'h03D7,
  parameter logic [DATA_W-1:0] BASE     = 8'hCC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output bus_dec_t          dec_o,
  output logic [DATA_W-1:0] index_o,
  output logic              in_win_o,
  output logic [SEL_W-1:0]  pos_o
);
  logic [DATA_W-1:0] index_q;
  logic [DATA_W-1:0] off;

  always_comb begin
    dec_o.idx_wr = wr_i && (addr_i == IDX_PORT);
    dec_o.idx_rd = rd_i && (addr_i == IDX_PORT);
    dec_o.dat_wr = wr_i && (addr_i == DAT_PORT);
    dec_o.dat_rd = rd_i && (addr_i == DAT_PORT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          index_q <= '0;
    else if (dec_o.idx_wr) index_q <= wdata_i;
  end

  // offset wraps below BASE, so one compare covers both window edges
  assign off      = index_q - BASE;
  assign in_win_o = off < DATA_W'(NUM);
  assign pos_o    = off[SEL_W-1:0];
  assign index_o  = index_q;
endmodule

// File: rtl/mclk_commit_seq.sv
module mclk_commit_seq #(
  parameter int NUM   = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] pos_i,
  output logic             commit_o,
  output logic             update_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM - 1);

  logic [SEL_W-1:0] step_q, step_d;
  logic             accept, is_last;

  assign is_last  = pos_i == LAST;
  assign accept   = (pos_i == '0) || (pos_i == step_q);
  assign commit_o = wr_en_i && accept && is_last;

  always_comb begin
    step_d = step_q;
    if (wr_en_i) begin
      if (accept && !is_last) step_d = pos_i + SEL_W'(1);
      else                    step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      update_o <= 1'b0;
    end else begin
      step_q   <= step_d;
      update_o <= commit_o;
    end
  end
endmodule

// File: rtl/mclk_param_bank.sv
module mclk_param_bank #(
  parameter int NUM    = 3,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  parameter logic [NUM*DATA_W-1:0] RESET_VALS = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [SEL_W-1:0]      pos_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  commit_i,
  output logic [NUM*DATA_W-1:0] staged_o,
  output logic [NUM*DATA_W-1:0] active_o
);
  for (genvar k = 0; k < NUM; k++) begin : g_slot
    localparam logic [DATA_W-1:0] RST = RESET_VALS[k*DATA_W +: DATA_W];
    logic [DATA_W-1:0] stg_q, stg_d, act_q;

    assign stg_d = (wr_en_i && pos_i == SEL_W'(k)) ? wdata_i : stg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q <= RST;
        act_q <= RST;
      end else begin
        stg_q <= stg_d;
        // commit uses next-state so the closing write lands too
        if (commit_i) act_q <= stg_d;
      end
    end

    assign staged_o[k*DATA_W +: DATA_W] = stg_q;
    assign active_o[k*DATA_W +: DATA_W] = act_q;
  end
endmodule

// File: rtl/mclk_param_regs.sv
module mclk_param_regs
  import mclk_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM    = 3,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h03D6,
  parameter logic [ADDR_W-1:0] DAT_PORT = 16'h03D7,
  parameter logic [DATA_W-1:0] BASE     = 8'hCC,
  parameter logic [NUM*DATA_W-1:0] RESET_VALS = 24'h02_0D_1E
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM*DATA_W-1:0] active_o,
  output logic                  update_o
);
  localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1;

  bus_dec_t              dec;
  logic [DATA_W-1:0]     index_q;
  logic                  in_win;
  logic [SEL_W-1:0]      pos;
  logic                  slot_wr, commit;
  logic [NUM*DATA_W-1:0] staged;

  mclk_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM(NUM), .SEL_W(SEL_W),
    .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT), .BASE(BASE)
  ) i_dec (
    .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i,
    .dec_o(dec), .index_o(index_q), .in_win_o(in_win), .pos_o(pos)
  );

  assign slot_wr = dec.dat_wr && in_win;

  mclk_commit_seq #(.NUM(NUM), .SEL_W(SEL_W)) i_seq (
    .clk_i, .rst_ni, .wr_en_i(slot_wr), .pos_i(pos),
    .commit_o(commit), .update_o(update_o)
  );

  mclk_param_bank #(
    .NUM(NUM), .DATA_W(DATA_W), .SEL_W(SEL_W), .RESET_VALS(RESET_VALS)
  ) i_bank (
    .clk_i, .rst_ni, .wr_en_i(slot_wr), .pos_i(pos), .wdata_i,
    .commit_i(commit), .staged_o(staged), .active_o(active_o)
  );

  always_comb begin
    rdata_o = '0;
    if (dec.idx_rd)               rdata_o = index_q;
    else if (dec.dat_rd && in_win) rdata_o = staged[pos*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/mclk_param_regs_chk.sv
module mclk_param_regs_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM    = 3,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h03D6,
  parameter logic [ADDR_W-1:0] DAT_PORT = 16'h03D7,
  parameter logic [DATA_W-1:0] BASE     = 8'hCC
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  rd_i,
  input logic                  wr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [NUM*DATA_W-1:0] active_o,
  input logic                  update_o,
  input logic [DATA_W-1:0]     index_q,
  input logic [NUM*DATA_W-1:0] staged
);
  logic [DATA_W-1:0] rel;
  logic              win, last_wr;
  assign rel     = index_q - BASE;
  assign win     = rel < DATA_W'(NUM);
  assign last_wr = wr_i && addr_i == DAT_PORT && rel == DATA_W'(NUM - 1);

  a_r1_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == IDX_PORT) |=> index_q == $past(wdata_i));

  a_r3_active_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> $stable(active_o));

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  a_r4_after_last_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(last_wr));

  a_r4_commit_matches_staged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> active_o == staged);

  a_r8_oob_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == DAT_PORT && !win) |-> rdata_o == '0);

  a_r11_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

bind mclk_param_regs mclk_param_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM(NUM),
  .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT), .BASE(BASE)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .active_o(active_o),
  .update_o(update_o), .index_q(index_q), .staged(staged)
);

// File: tb/test_mclk_param_regs.sv
module test_mclk_param_regs;
  localparam logic [15:0] IDXP = 16'h03D6;
  localparam logic [15:0] DATP = 16'h03D7;
  localparam logic [23:0] RV   = 24'h3C_5A_A5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] active;
  logic        upd;

  int vecs = 0, errs = 0;
  string cur_req = "R9";

  always #2 clk = ~clk;

  mclk_param_regs #(
    .ADDR_W(16), .DATA_W(8), .NUM(3), .IDX_PORT(IDXP), .DAT_PORT(DATP),
    .BASE(8'hCC), .RESET_VALS(RV)
  ) i_mclk_param_regs (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .active_o(active), .update_o(upd)
  );

  // behavioural reference
  logic [7:0] m_idx;
  logic [7:0] m_stg [3];
  logic [7:0] m_act [3];
  int         m_step;
  logic       m_upd;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_idx = 8'h00; m_step = 0; m_upd = 1'b0;
      for (int i = 0; i < 3; i++) begin
        m_stg[i] = RV[i*8 +: 8];
        m_act[i] = RV[i*8 +: 8];
      end
    end else begin
      m_upd = 1'b0;
      if (wr && addr == IDXP) m_idx = wdata;
      else if (wr && addr == DATP && m_idx >= 8'hCC && m_idx <= 8'hCE) begin
        int p;
        p = int'(m_idx) - 'hCC;
        m_stg[p] = wdata;
        if (p == 0) m_step = 1;
        else if (p == m_step) begin
          if (p == 2) begin
            for (int i = 0; i < 3; i++) m_act[i] = m_stg[i];
            m_upd = 1'b1;
            m_step = 0;
          end else m_step = p + 1;
        end else m_step = 0;
      end
    end
  end

  function automatic logic [7:0] m_read(logic [15:0] a);
    if (a == IDXP) return m_idx;
    if (a == DATP && m_idx >= 8'hCC && m_idx <= 8'hCE) return m_stg[int'(m_idx) - 'hCC];
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  // R3/R4 compared every clock against the reference
  always @(negedge clk) begin
    chk({cur_req, " active"}, 32'(active), 32'({m_act[2], m_act[1], m_act[0]}));
    chk({cur_req, " update"}, 32'(upd), 32'(m_upd));
  end

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    bus_wr(IDXP, idx);
    bus_wr(DATP, d);
  endtask

  task automatic bus_rd(string req, logic [15:0] a);
    @(negedge clk); #1;
    addr = a; rd = 1'b1;
    #1 chk(req, 32'(rdata), 32'(m_read(a)));
    rd = 1'b0;
  endtask

  task automatic reg_rd(string req, logic [7:0] idx);
    bus_wr(IDXP, idx);
    bus_rd(req, DATP);
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R9";
    chk("R9 update in reset", 32'(upd), 32'h0);
    chk("R9 active in reset", 32'(active), 32'(RV));
    #1 rst_ni = 1'b1;
    bus_rd("R9 index reset 00", IDXP);
    reg_rd("R9 staged0 reset", 8'hCC);
    reg_rd("R9 staged2 reset", 8'hCE);

    cur_req = "R1";
    bus_wr(IDXP, 8'h77);
    bus_rd("R1 index readback", IDXP);

    cur_req = "R2";
    reg_wr(8'hCD, 8'h44);
    reg_rd("R2 staged CD readback", 8'hCD);
    chk("R3 active after lone write", 32'(active), 32'(RV));

    cur_req = "R4";
    reg_wr(8'hCC, 8'h11); reg_wr(8'hCD, 8'h22); reg_wr(8'hCE, 8'h33);
    @(negedge clk);
    chk("R10 M field", 32'(active[7:0]), 32'h11);
    chk("R10 N field", 32'(active[15:8]), 32'h22);
    chk("R10 third field", 32'(active[23:16]), 32'h33);

    cur_req = "R5";
    reg_wr(8'hCC, 8'h01); reg_wr(8'hCD, 8'h02);
    reg_wr(8'hCC, 8'h03); reg_wr(8'hCD, 8'h04); reg_wr(8'hCE, 8'h05);
    @(negedge clk);
    chk("R5 restart commit", 32'(active), 32'h05_04_03);

    cur_req = "R6";
    reg_wr(8'hCC, 8'h61); reg_wr(8'hCE, 8'h63);
    reg_wr(8'hCD, 8'h62); reg_wr(8'hCE, 8'h64);
    reg_wr(8'hCC, 8'h65); reg_wr(8'hCD, 8'h66); reg_wr(8'hCD, 8'h67); reg_wr(8'hCE, 8'h68);
    chk("R6 no commit", 32'(active), 32'h05_04_03);
    reg_rd("R6 staged still written", 8'hCE);

    cur_req = "R7";
    reg_wr(8'hCC, 8'h71);
    reg_wr(8'hD0, 8'hEE); bus_rd("R7 read between", IDXP);
    reg_wr(8'hCD, 8'h72);
    reg_wr(8'h10, 8'hEE); reg_rd("R7 read staged between", 8'hCC);
    reg_wr(8'hCE, 8'h73);
    @(negedge clk);
    chk("R7 commit survives", 32'(active), 32'h73_72_71);

    cur_req = "R8";
    reg_wr(8'hCB, 8'h99); reg_wr(8'hCF, 8'h99); reg_wr(8'h00, 8'h99);
    reg_rd("R8 CB reads 00", 8'hCB);
    reg_rd("R8 CF reads 00", 8'hCF);
    reg_rd("R8 CC unchanged", 8'hCC);
    reg_rd("R8 CE unchanged", 8'hCE);

    cur_req = "R11";
    bus_rd("R11 other address", 16'h03D5);
    @(negedge clk); #1 addr = DATP;
    #1 chk("R11 no strobe", 32'(rdata), 32'h0);

    cur_req = "R9";
    reg_wr(8'hCC, 8'h81);
    @(negedge clk); #1 rst_ni = 1'b0;
    @(negedge clk);
    chk("R9 mid-sequence reset", 32'(active), 32'(RV));
    #1 rst_ni = 1'b1;
    reg_wr(8'hCD, 8'h82); reg_wr(8'hCE, 8'h83);
    chk("R9 sequence idle after reset", 32'(active), 32'(RV));

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule